// File: doc/BRIEF.md
# Video Color Subcarrier Phase Synthesizer

This block produces the colour subcarrier phase for an analog television encoder. A 32-bit phase accumulator advances by a programmed increment on every pixel-clock enable, and the top byte of the accumulator, shifted by an 8-bit programmable offset, is the phase word for a downstream sine lookup. Software derives the increment from the number of output clocks per line and the wanted subcarrier frequency. Loading that increment arms the chroma-enable flag.

To keep the subcarrier locked to horizontal sync, the accumulator returns to zero phase on the leading edge of vertical sync once per colour-field sequence. That is every fourth field in NTSC mode and every eighth field in PAL and SECAM modes. A control bit turns this realignment off. In SECAM mode the block uses two increments: one on the blue-difference line and one on the red-difference line, swapping at every line start. Chroma is also restricted there to two fixed windows of active lines.

A two-state controller orders the work. State ST_WAIT_INC holds the accumulator at zero and mutes chroma. The transition "arm" fires when the last byte of the first increment is written and moves the controller to ST_RUN. ST_RUN has a single transition, "stay", back to itself, because only reset returns the controller to ST_WAIT_INC.

Top module: `subcarrier_synth`

## Requirements
- R1: After reset, phase_out is 0 and chroma_en is 0.
- R2: chroma_en stays 0, and the accumulator stays at zero whatever pix_en does, until a byte is written to address 3, the last byte of the first increment. Writes to addresses 0 to 2 alone do not arm it.
- R3: In ST_RUN, each cycle with pix_en high adds the active increment to the 32-bit accumulator, modulo 2^32. phase_out equals accumulator bits 31:24 plus the offset, modulo 256.
- R4: The first increment is written little-endian at addresses 0 to 3. The second is written at addresses 4 to 7. Each increment changes as a whole only when its highest byte, at address 3 or 7, is written. Until then the accumulator keeps using the previous value.
- R5: In NTSC mode (control bits 1:0 = 0, and likewise for the unused code 3), the accumulator is cleared on every fourth vs_lead counted from reset. A 3-bit field counter advances on every vs_lead, and the clear happens when its two low bits are 3.
- R6: In PAL mode (code 1) and SECAM mode (code 2), the clear happens on every eighth vs_lead, when the field counter is 7.
- R7: Control bit 2 set to 1 suppresses the clear. The field counter keeps advancing while the clear is suppressed.
- R8: When a clear and a pix_en advance fall in the same cycle, the clear wins and the accumulator becomes 0.
- R9: Control bit 3 set to 1 forces chroma_en to 0. Setting it back to 0 restores chroma_en.
- R10: In SECAM mode, chroma_en is 1 only on lines 23 to 310 and 336 to 623, bounds included. Control bit 4 set to 1 removes this line restriction.
- R11: In SECAM mode the first increment drives the first line after reset. Each line_start pulse swaps to the other increment. In NTSC and PAL modes only the first increment is used.
- R12: The phase offset is written at address 8. One step equals 360/256 degrees, and the addition wraps modulo 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_en | input | 1 | Pixel-clock enable; advances the accumulator |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register byte address (0-3 first increment, 4-7 second increment, 8 offset, 9 control) |
| wr_data | input | 8 | Register write byte |
| vs_lead | input | 1 | One-cycle strobe on the leading edge of vertical sync (field start) |
| line_start | input | 1 | One-cycle strobe at the start of each line |
| line_num | input | 10 | Current line number |
| phase_out | output | 8 | Subcarrier phase word |
| chroma_en | output | 1 | Chroma output enable |

## Verification
The periodic zero-phase clear and the normal increment step act on the same accumulator. They meet whenever the vertical-sync strobe and a pixel enable are high in the same cycle. The bench drives both together on the field that is due for realignment and expects a phase of exactly the offset. It then drives both together on the following field, which is not due, and expects a normal single step. This shows that the clear takes priority only when realignment actually fires.

// File: rtl/sc_pkg.sv
package sc_pkg;

    typedef enum logic [1:0] {
        STD_NTSC  = 2'd0,
        STD_PAL   = 2'd1,
        STD_SECAM = 2'd2,
        STD_SPARE = 2'd3
    } tv_std_e;

    typedef struct packed {
        logic    gate_off;
        logic    chroma_off;
        logic    no_realign;
        tv_std_e std;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic {
        ST_WAIT_INC = 1'b0,
        ST_RUN      = 1'b1
    } state_e;

endpackage

// File: rtl/sc_wide_reg.sv
module sc_wide_reg #(
    parameter int W    = 32,
    parameter int AW   = 4,
    parameter int BASE = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    output logic [W-1:0]  value
);
    localparam int NB   = W / 8;
    localparam int LOWW = W - 8;

    logic [LOWW-1:0] shadow;

    // Shadow bytes below the top one collect writes without touching value.
    for (genvar k = 0; k < NB - 1; k++) begin : g_shadow
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shadow[8*k +: 8] <= '0;
            end else if (wr_en && wr_addr == AW'(BASE + k)) begin
                shadow[8*k +: 8] <= wr_data;
            end
        end
    end

    // The top byte commits the whole word in one step.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (wr_en && wr_addr == AW'(BASE + NB - 1)) begin
            value <= {wr_data, shadow};
        end
    end
endmodule

// File: rtl/sc_regs.sv
module sc_regs
    import sc_pkg::*;
#(
    parameter int ACC_W   = 32,
    parameter int PHASE_W = 8,
    parameter int AW      = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [7:0]         wr_data,
    output logic [ACC_W-1:0]   inc_db,
    output logic [ACC_W-1:0]   inc_dr,
    output logic [PHASE_W-1:0] phase_ofs,
    output ctrl_t              ctrl,
    output logic               arm
);
    localparam int NB       = ACC_W / 8;
    localparam int OFS_ADDR = 2 * NB;
    localparam int CTL_ADDR = 2 * NB + 1;

    logic [ACC_W-1:0] inc_arr [2];

    for (genvar c = 0; c < 2; c++) begin : g_inc
        sc_wide_reg #(
            .W   (ACC_W),
            .AW  (AW),
            .BASE(c * NB)
        ) i_inc (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_en),
            .wr_addr(wr_addr),
            .wr_data(wr_data),
            .value  (inc_arr[c])
        );
    end

    assign inc_db = inc_arr[0];
    assign inc_dr = inc_arr[1];
    assign arm    = wr_en && (wr_addr == AW'(NB - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_ofs <= '0;
            ctrl      <= '0;
        end else if (wr_en) begin
            if (wr_addr == AW'(OFS_ADDR)) phase_ofs <= wr_data[PHASE_W-1:0];
            if (wr_addr == AW'(CTL_ADDR)) ctrl      <= ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end
endmodule

// File: rtl/sc_fieldseq.sv
module sc_fieldseq
    import sc_pkg::*;
#(
    parameter int FCNT_W = 3
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    vs_lead,
    input  tv_std_e std,
    input  logic    no_realign,
    output logic    clear_req
);
    logic [FCNT_W-1:0] fcnt;
    logic              due;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       fcnt <= '0;
        else if (vs_lead) fcnt <= fcnt + 1'b1;
    end

    // Four-field sequence looks at the two low bits, eight-field at all three.
    always_comb begin
        unique case (std)
            STD_PAL, STD_SECAM: due = (fcnt == '1);
            default:            due = (fcnt[1:0] == 2'b11);
        endcase
    end

    assign clear_req = vs_lead && due && !no_realign;
endmodule

// File: rtl/sc_accum.sv
module sc_accum #(
    parameter int ACC_W   = 32,
    parameter int PHASE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               adv,
    input  logic               clr,
    input  logic [ACC_W-1:0]   inc,
    input  logic [PHASE_W-1:0] ofs,
    output logic [PHASE_W-1:0] phase
);
    logic [ACC_W-1:0] acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          acc_q <= '0;
        else if (clr)        acc_q <= '0;
        else if (run && adv) acc_q <= acc_q + inc;
    end

    assign phase = acc_q[ACC_W-1 -: PHASE_W] + ofs;
endmodule

// File: rtl/subcarrier_synth.sv
module subcarrier_synth
    import sc_pkg::*;
#(
    parameter int ACC_W   = 32,
    parameter int PHASE_W = 8,
    parameter int AW      = 4,
    parameter int LINE_W  = 10,
    parameter int WIN0_LO = 23,
    parameter int WIN0_HI = 310,
    parameter int WIN1_LO = 336,
    parameter int WIN1_HI = 623
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix_en,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [7:0]         wr_data,
    input  logic               vs_lead,
    input  logic               line_start,
    input  logic [LINE_W-1:0]  line_num,
    output logic [PHASE_W-1:0] phase_out,
    output logic               chroma_en
);
    localparam logic [LINE_W-1:0] L0_LO = LINE_W'(WIN0_LO);
    localparam logic [LINE_W-1:0] L0_HI = LINE_W'(WIN0_HI);
    localparam logic [LINE_W-1:0] L1_LO = LINE_W'(WIN1_LO);
    localparam logic [LINE_W-1:0] L1_HI = LINE_W'(WIN1_HI);

    logic [ACC_W-1:0]   inc_db, inc_dr, inc_sel;
    logic [PHASE_W-1:0] phase_ofs;
    ctrl_t              ctrl_q;
    logic               arm, clear_req, run;
    logic               is_secam, gate_off, chroma_off, no_realign;
    logic               dr_line, in_window, line_ok;
    state_e             state_q, state_d;

    sc_regs #(.ACC_W(ACC_W), .PHASE_W(PHASE_W), .AW(AW)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .inc_db   (inc_db),
        .inc_dr   (inc_dr),
        .phase_ofs(phase_ofs),
        .ctrl     (ctrl_q),
        .arm      (arm)
    );

    assign is_secam   = (ctrl_q.std == STD_SECAM);
    assign gate_off   = ctrl_q.gate_off;
    assign chroma_off = ctrl_q.chroma_off;
    assign no_realign = ctrl_q.no_realign;

    sc_fieldseq #(.FCNT_W(3)) i_fieldseq (
        .clk       (clk),
        .rst_n     (rst_n),
        .vs_lead   (vs_lead),
        .std       (ctrl_q.std),
        .no_realign(no_realign),
        .clear_req (clear_req)
    );

    // Colour-difference line parity, swapped only while in SECAM mode.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       dr_line <= 1'b0;
        else if (line_start && is_secam)  dr_line <= !dr_line;
    end

    assign inc_sel = (is_secam && dr_line) ? inc_dr : inc_db;

    sc_accum #(.ACC_W(ACC_W), .PHASE_W(PHASE_W)) i_accum (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .adv  (pix_en),
        .clr  (clear_req),
        .inc  (inc_sel),
        .ofs  (phase_ofs),
        .phase(phase_out)
    );

    assign in_window = ((line_num >= L0_LO) && (line_num <= L0_HI)) ||
                       ((line_num >= L1_LO) && (line_num <= L1_HI));
    assign line_ok   = !is_secam || gate_off || in_window;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT_INC;
        else        state_q <= state_d;
    end

    // Next state: "arm" and "stay"
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_INC: if (arm) state_d = ST_RUN;
            ST_RUN:      state_d = ST_RUN;
        endcase
    end

    // Outputs per state
    always_comb begin
        run       = 1'b0;
        chroma_en = 1'b0;
        unique case (state_q)
            ST_WAIT_INC: begin
                run       = 1'b0;
                chroma_en = 1'b0;
            end
            ST_RUN: begin
                run       = 1'b1;
                chroma_en = !chroma_off && line_ok;
            end
        endcase
    end
endmodule

// File: rtl/sc_checkers.sv
module sc_accum_checker #(
    parameter int ACC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             adv,
    input logic             clr,
    input logic [ACC_W-1:0] inc,
    input logic [ACC_W-1:0] acc_q
);
    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_q == '0));

    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && adv && !clr) |=> (acc_q == $past(acc_q) + $past(inc)));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (acc_q == '0));
endmodule

module sc_top_checker #(
    parameter int LINE_W  = 10,
    parameter int WIN0_LO = 23,
    parameter int WIN1_HI = 623
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              chroma_en,
    input logic              chroma_off,
    input logic              clear_req,
    input logic              vs_lead,
    input logic              no_realign,
    input logic              is_secam,
    input logic              gate_off,
    input logic [LINE_W-1:0] line_num
);
    localparam logic [LINE_W-1:0] LO = LINE_W'(WIN0_LO);
    localparam logic [LINE_W-1:0] HI = LINE_W'(WIN1_HI);

    assert_mute_until_armed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !chroma_en);

    assert_chroma_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        chroma_off |-> !chroma_en);

    assert_secam_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (is_secam && !gate_off && ((line_num < LO) || (line_num > HI))) |-> !chroma_en);

    assert_realign_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        no_realign |-> !clear_req);

    assert_clear_on_vs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clear_req |-> vs_lead);
endmodule

bind sc_accum sc_accum_checker #(.ACC_W(ACC_W)) i_acc_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .adv  (adv),
    .clr  (clr),
    .inc  (inc),
    .acc_q(acc_q)
);

bind subcarrier_synth sc_top_checker #(
    .LINE_W (LINE_W),
    .WIN0_LO(WIN0_LO),
    .WIN1_HI(WIN1_HI)
) i_top_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .chroma_en (chroma_en),
    .chroma_off(chroma_off),
    .clear_req (clear_req),
    .vs_lead   (vs_lead),
    .no_realign(no_realign),
    .is_secam  (is_secam),
    .gate_off  (gate_off),
    .line_num  (line_num)
);

// File: tb/test_subcarrier_synth.sv
module test_subcarrier_synth;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pix_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       vs_lead = 1'b0;
    logic       line_start = 1'b0;
    logic [9:0] line_num = '0;
    logic [7:0] phase_out;
    logic       chroma_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    subcarrier_synth i_subcarrier_synth (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_en    (pix_en),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .vs_lead   (vs_lead),
        .line_start(line_start),
        .line_num  (line_num),
        .phase_out (phase_out),
        .chroma_en (chroma_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pix_en = 0; wr_en = 0; vs_lead = 0; line_start = 0; line_num = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_inc(input int base, input logic [31:0] v);
        for (int k = 0; k < 4; k++) wr(4'(base + k), v[8*k +: 8]);
    endtask

    task automatic pix(input int n);
        pix_en = 1'b1;
        repeat (n) @(negedge clk);
        pix_en = 1'b0;
    endtask

    task automatic vs(input int n);
        repeat (n) begin
            vs_lead = 1'b1;
            @(negedge clk);
            vs_lead = 1'b0;
        end
    endtask

    task automatic lstart();
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 phase after reset", phase_out, 0);
        chk("R1 chroma after reset", chroma_en, 0);
    endtask

    task automatic t_arm();
        do_reset();
        pix(3);
        chk("R2 accumulator held before arming", phase_out, 0);
        wr(4'd0, 8'h00); wr(4'd1, 8'h00); wr(4'd2, 8'h00);
        chk("R2 partial increment does not arm", chroma_en, 0);
        wr(4'd3, 8'h01);
        chk("R2 armed by last byte", chroma_en, 1);
        pix(5);
        chk("R3 five steps of one", phase_out, 5);
    endtask

    task automatic t_atomic();
        do_reset();
        load_inc(0, 32'h0100_0000);
        pix(2);
        wr(4'd0, 8'h00); wr(4'd1, 8'h00); wr(4'd2, 8'h80);
        pix(2);
        chk("R4 old increment kept until top byte", phase_out, 4);
        wr(4'd3, 8'h02);
        pix(2);
        chk("R4 new increment after top byte", phase_out, 9);
    endtask

    task automatic t_wrap();
        do_reset();
        load_inc(0, 32'h4000_0000);
        pix(4);
        chk("R3 accumulator wraps mod 2^32", phase_out, 0);
        pix(1);
        chk("R3 step after wrap", phase_out, 8'h40);
    endtask

    task automatic t_offset();
        do_reset();
        load_inc(0, 32'h0100_0000);
        pix(3);
        wr(4'd8, 8'hFE);
        chk("R12 offset wraps mod 256", phase_out, 8'h01);
    endtask

    task automatic t_ntsc();
        do_reset();
        load_inc(0, 32'h0100_0000);
        pix(5);
        vs(3);
        chk("R5 no clear before fourth field", phase_out, 5);
        vs(1);
        chk("R5 clear on fourth field", phase_out, 0);
        pix(2);
        vs(3);
        chk("R5 no clear on fields five to seven", phase_out, 2);
        vs(1);
        chk("R5 clear on eighth field", phase_out, 0);
    endtask

    task automatic t_pal();
        do_reset();
        wr(4'd9, 8'h01);
        load_inc(0, 32'h0100_0000);
        pix(7);
        vs(7);
        chk("R6 PAL no clear before eighth field", phase_out, 7);
        vs(1);
        chk("R6 PAL clear on eighth field", phase_out, 0);
    endtask

    task automatic t_no_realign();
        do_reset();
        wr(4'd9, 8'h04);
        load_inc(0, 32'h0100_0000);
        pix(5);
        vs(2);
        wr(4'd9, 8'h00);
        vs(1);
        chk("R7 suppressed clear, counter still counted", phase_out, 5);
        vs(1);
        chk("R7 clear resumes on fourth counted field", phase_out, 0);
        wr(4'd9, 8'h04);
        pix(3);
        vs(4);
        chk("R7 no clear while disabled", phase_out, 3);
    endtask

    task automatic t_collision();
        do_reset();
        load_inc(0, 32'h0100_0000);
        pix(3);
        vs(3);
        vs_lead = 1'b1; pix_en = 1'b1;
        @(negedge clk);
        vs_lead = 1'b0; pix_en = 1'b0;
        chk("R8 clear wins over step", phase_out, 0);
        vs_lead = 1'b1; pix_en = 1'b1;
        @(negedge clk);
        vs_lead = 1'b0; pix_en = 1'b0;
        chk("R8 step taken when field not due", phase_out, 1);
    endtask

    task automatic t_chroma_off();
        do_reset();
        load_inc(0, 32'h0100_0000);
        wr(4'd9, 8'h08);
        chk("R9 chroma forced off", chroma_en, 0);
        wr(4'd9, 8'h00);
        chk("R9 chroma restored", chroma_en, 1);
    endtask

    task automatic t_secam_window();
        int lines [8] = '{22, 23, 310, 311, 335, 336, 623, 624};
        int expv  [8] = '{0, 1, 1, 0, 0, 1, 1, 0};
        do_reset();
        wr(4'd9, 8'h02);
        load_inc(0, 32'h0100_0000);
        for (int i = 0; i < 8; i++) begin
            line_num = 10'(lines[i]);
            @(negedge clk);
            chk("R10 SECAM line window", chroma_en, expv[i]);
        end
        wr(4'd9, 8'h12);
        line_num = 10'd22;
        @(negedge clk);
        chk("R10 gating removed", chroma_en, 1);
    endtask

    task automatic t_secam_alt();
        do_reset();
        wr(4'd9, 8'h02);
        load_inc(4, 32'h1000_0000);
        load_inc(0, 32'h0100_0000);
        pix(1);
        chk("R11 first line uses first increment", phase_out, 8'h01);
        lstart();
        pix(1);
        chk("R11 second line uses second increment", phase_out, 8'h11);
        lstart();
        pix(1);
        chk("R11 third line back to first increment", phase_out, 8'h12);
        wr(4'd9, 8'h00);
        lstart();
        pix(1);
        chk("R11 NTSC ignores second increment", phase_out, 8'h13);
    endtask

    initial begin
        t_reset();
        t_arm();
        t_atomic();
        t_wrap();
        t_offset();
        t_ntsc();
        t_pal();
        t_no_realign();
        t_collision();
        t_chroma_off();
        t_secam_window();
        t_secam_alt();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule